// File: doc/BRIEF.md
# Integer Execute Stage for a 32-bit Base ISA

This block is the integer compute slice of a small 32-bit core. Each cycle it may take one instruction word, the address that word was fetched from, and a valid strobe. It handles four instruction groups: register-immediate arithmetic, register-register arithmetic, load-upper-immediate and add-upper-immediate-to-PC. Operands come from an internal register file of 32 registers, each 32 bits wide, and the result is written back to it.

Register indices and the immediate sign bit are taken from fixed positions in the instruction word, so the register file read does not wait for the format decode. The operation is chosen from funct3 plus one extra instruction bit (bit 30). Results wrap modulo 2^32. There are no condition flags and no arithmetic traps.

The block reports words it cannot execute on an illegal output and writes nothing for them. It marks the canonical no-operation word on a separate output. A combinational debug read port lets a testbench or debugger read any register.

Top module: `int_exec_unit`

## Requirements
- R1: The source and destination indices come from fixed slices in every format: rs1 = inst[19:15], rs2 = inst[24:20], rd = inst[11:7].
- R2: Every immediate is sign-extended from inst[31]. The I immediate is inst[31:20]. The U immediate is inst[31:12] followed by 12 zero bits.
- R3: Register x0 always reads as zero, on the debug port and as an operand. Any result aimed at x0 is discarded.
- R4: Addition and subtraction wrap modulo 2^32, and the result is always written. funct3 000 is add. In the register-register opcode 0110011, inst[30]=1 selects subtract. In the immediate opcode 0010011, funct3 000 is always add.
- R5: funct3 001 is a left shift and funct3 101 is a right shift. For the right shift, inst[30]=1 makes it arithmetic and inst[30]=0 makes it logical. Immediate shifts take the amount from inst[24:20]. Register shifts take it from rs2[4:0].
- R6: funct3 010 is a signed set-less-than and funct3 011 is an unsigned set-less-than. The second operand is rs2 or the sign-extended I immediate. The result is 1 or 0.
- R7: funct3 100 is XOR, 110 is OR and 111 is AND, in both the register-register and the immediate forms.
- R8: Opcode 0110111 writes the U immediate. Opcode 0010111 writes the U immediate plus the instruction's PC.
- R9: nopSeen is 1 exactly when valid is high and the word is 0x00000013. That word changes no register.
- R10: illegal is 1 when valid is high and the word is not a supported encoding, and then no register is written. The supported opcodes are 0010011, 0110011, 0110111 and 0010111. In 0110011, funct7 must be 0000000, or 0100000 with funct3 000 or 101. In 0010011, funct3 001 needs inst[31:25]=0000000, and funct3 101 needs inst[31:25] to be 0000000 or 0100000.
- R11: The register write happens on the rising edge that ends the valid cycle. No register changes while valid is low. dbgData is a combinational read. A synchronous reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction word and PC are valid this cycle |
| instWord | input | 32 | Instruction word |
| instPc | input | XLEN | Address of the instruction word |
| dbgAddr | input | IDXW | Register index for the debug read |
| dbgData | output | XLEN | Contents of the register selected by dbgAddr |
| illegal | output | 1 | The current valid word is unsupported or reserved |
| nopSeen | output | 1 | The current valid word is the canonical no-operation |

## Verification
illegal and nopSeen are combinational. The bench samples them 1 ns after it drives the word, inside the valid cycle. A register result lands on the first rising edge after the word is driven, and dbgData is a combinational read of the register file. The bench therefore reads the destination at the falling edge that follows that rising edge, with valid already low. For the no-effect cases (x0 targets, the no-operation word, illegal words, and words present while valid is low), the bench compares all 32 registers against its own expected copy at the same point.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } aluOp_e;

  typedef enum logic [1:0] {
    SRC_A_REG, SRC_A_PC, SRC_A_ZERO
  } srcA_e;

  typedef struct packed {
    logic   wrEn;
    aluOp_e aluOp;
    srcA_e  srcA;
    logic   useImm;
    logic   immUpper;
  } ctlStrobes_t;

  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_UPPER = 7'b0110111;
  localparam logic [6:0] OPC_PCREL = 7'b0010111;
  localparam logic [31:0] NOP_WORD = 32'h0000_0013;

endpackage

// File: rtl/int_exec_ctrl.sv
module int_exec_ctrl
  import int_exec_pkg::*;
(
  input  logic        instValid,
  input  logic [31:0] instWord,
  output ctlStrobes_t ctl,
  output logic        illegal,
  output logic        nopSeen
);

  logic [6:0] opc;
  logic [2:0] fn3;
  logic [6:0] fn7;
  logic       altBit;
  logic       legal;
  logic       f7Clean;
  aluOp_e     baseOp;

  assign opc     = instWord[6:0];
  assign fn3     = instWord[14:12];
  assign fn7     = instWord[31:25];
  assign altBit  = instWord[30];
  assign f7Clean = (fn7 & 7'b1011111) == 7'b0;

  // operation from funct3 plus the single alternate bit
  always_comb begin
    unique case (fn3)
      3'b000:  baseOp = ALU_ADD;
      3'b001:  baseOp = ALU_SLL;
      3'b010:  baseOp = ALU_SLT;
      3'b011:  baseOp = ALU_SLTU;
      3'b100:  baseOp = ALU_XOR;
      3'b101:  baseOp = altBit ? ALU_SRA : ALU_SRL;
      3'b110:  baseOp = ALU_OR;
      default: baseOp = ALU_AND;
    endcase
  end

  always_comb begin
    ctl          = '0;
    ctl.aluOp    = ALU_ADD;
    ctl.srcA     = SRC_A_REG;
    legal        = 1'b0;
    unique case (opc)
      OPC_IMM: begin
        ctl.useImm = 1'b1;
        ctl.aluOp  = baseOp;
        if (fn3 == 3'b001)      legal = (fn7 == 7'b0);
        else if (fn3 == 3'b101) legal = f7Clean;
        else                    legal = 1'b1;
      end
      OPC_REG: begin
        ctl.aluOp = (fn3 == 3'b000 && altBit) ? ALU_SUB : baseOp;
        legal     = f7Clean && (!altBit || fn3 == 3'b000 || fn3 == 3'b101);
      end
      OPC_UPPER: begin
        ctl.srcA     = SRC_A_ZERO;
        ctl.useImm   = 1'b1;
        ctl.immUpper = 1'b1;
        legal        = 1'b1;
      end
      OPC_PCREL: begin
        ctl.srcA     = SRC_A_PC;
        ctl.useImm   = 1'b1;
        ctl.immUpper = 1'b1;
        legal        = 1'b1;
      end
      default: legal = 1'b0;
    endcase
    ctl.wrEn = instValid && legal;
  end

  assign illegal = instValid && !legal;
  assign nopSeen = instValid && (instWord == NOP_WORD);

endmodule

// File: rtl/int_exec_regs.sv
module int_exec_regs #(
  parameter int XLEN  = 32,
  parameter int REGS  = 32,
  parameter int IDXW  = $clog2(REGS),
  parameter int PORTS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic [IDXW-1:0]      wrIdx,
  input  logic [XLEN-1:0]      wrData,
  input  logic [PORTS-1:0][IDXW-1:0] rdIdx,
  output logic [PORTS-1:0][XLEN-1:0] rdData
);

  logic [XLEN-1:0] mem [REGS];

  // entry 0 is never written, so it stays at its reset value of zero
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REGS; i++) mem[i] <= '0;
    end else if (wrEn && wrIdx != '0) begin
      mem[wrIdx] <= wrData;
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    assign rdData[p] = (rdIdx[p] == '0) ? '0 : mem[rdIdx[p]];
  end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  aluOp_e          op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  logic [SHW-1:0] shamt;
  assign shamt = b[SHW-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLL:  y = a << shamt;
      ALU_SLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: y = {{(XLEN-1){1'b0}}, a < b};
      ALU_XOR:  y = a ^ b;
      ALU_SRL:  y = a >> shamt;
      ALU_SRA:  y = XLEN'($signed(a) >>> shamt);
      ALU_OR:   y = a | b;
      default:  y = a & b;
    endcase
  end

endmodule

// File: rtl/int_exec_dp.sv
module int_exec_dp
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int REGS = 32,
  parameter int IDXW = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  ctlStrobes_t     ctl,
  input  logic [31:0]     instWord,
  input  logic [XLEN-1:0] instPc,
  input  logic [IDXW-1:0] dbgAddr,
  output logic [XLEN-1:0] dbgData
);

  localparam int PORTS = 3;

  logic [PORTS-1:0][IDXW-1:0] rdIdx;
  logic [PORTS-1:0][XLEN-1:0] rdData;
  logic [XLEN-1:0] immI, immU, opA, opB, result;
  logic [IDXW-1:0] rdSel;

  // fixed slices, no format dependence
  assign rdIdx[0] = instWord[15 +: IDXW];
  assign rdIdx[1] = instWord[20 +: IDXW];
  assign rdIdx[2] = dbgAddr;
  assign rdSel    = instWord[7 +: IDXW];

  // sign always from bit 31
  assign immI = {{(XLEN-12){instWord[31]}}, instWord[31:20]};
  assign immU = {{(XLEN-32){instWord[31]}}, instWord[31:12], 12'b0};

  always_comb begin
    unique case (ctl.srcA)
      SRC_A_PC:   opA = instPc;
      SRC_A_ZERO: opA = '0;
      default:    opA = rdData[0];
    endcase
    if (!ctl.useImm)      opB = rdData[1];
    else if (ctl.immUpper) opB = immU;
    else                  opB = immI;
  end

  int_exec_alu #(.XLEN(XLEN)) u_alu (
    .op(ctl.aluOp), .a(opA), .b(opB), .y(result)
  );

  int_exec_regs #(.XLEN(XLEN), .REGS(REGS), .IDXW(IDXW), .PORTS(PORTS)) u_regs (
    .clk(clk), .rst(rst), .wrEn(ctl.wrEn), .wrIdx(rdSel), .wrData(result),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  assign dbgData = rdData[2];

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int REGS = 32,
  parameter int IDXW = $clog2(REGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instValid,
  input  logic [31:0]     instWord,
  input  logic [XLEN-1:0] instPc,
  input  logic [IDXW-1:0] dbgAddr,
  output logic [XLEN-1:0] dbgData,
  output logic            illegal,
  output logic            nopSeen
);

  ctlStrobes_t ctl;

  int_exec_ctrl u_ctrl (
    .instValid(instValid), .instWord(instWord), .ctl(ctl),
    .illegal(illegal), .nopSeen(nopSeen)
  );

  int_exec_dp #(.XLEN(XLEN), .REGS(REGS), .IDXW(IDXW)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .instWord(instWord), .instPc(instPc),
    .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

endmodule

// File: rtl/int_exec_chk.sv
module int_exec_chk #(
  parameter int XLEN = 32,
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            instValid,
  input logic [31:0]     instWord,
  input logic            illegal,
  input logic            nopSeen,
  input logic            wrEn,
  input logic [IDXW-1:0] dbgAddr,
  input logic [XLEN-1:0] dbgData
);

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wrEn); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> (!wrEn && !illegal && !nopSeen)); // R11

  AST_NOP_CANON: assert property (@(posedge clk) disable iff (rst)
    nopSeen |-> (instWord == 32'h0000_0013)); // R9

  AST_NOP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    nopSeen |-> !illegal); // R9

  AST_X0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dbgAddr == '0) |-> (dbgData == '0)); // R3

endmodule

bind int_exec_unit int_exec_chk #(.XLEN(XLEN), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
  .illegal(illegal), .nopSeen(nopSeen), .wrEn(ctl.wrEn),
  .dbgAddr(dbgAddr), .dbgData(dbgData)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

  localparam logic [6:0] OI = 7'b0010011, OR_ = 7'b0110011;
  localparam logic [6:0] OU = 7'b0110111, OP = 7'b0010111;

  logic clk = 1'b0, rst = 1'b1, instValid = 1'b0;
  logic [31:0] instWord = '0, instPc = '0, dbgData;
  logic [4:0] dbgAddr = '0;
  logic illegal, nopSeen;
  logic [31:0] mdl [32];
  int nChecks = 0, nFails = 0;
  logic sawIll, sawNop;

  always #5 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .instPc(instPc), .dbgAddr(dbgAddr), .dbgData(dbgData),
    .illegal(illegal), .nopSeen(nopSeen)
  );

  function automatic logic [31:0] encR(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                       logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] encI(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                       logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] encU(logic [19:0] imm, logic [4:0] rd, logic [6:0] op);
    return {imm, rd, op};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic exec(logic [31:0] w, logic [31:0] pc);
    @(negedge clk);
    instWord = w; instPc = pc; instValid = 1'b1;
    #1; sawIll = illegal; sawNop = nopSeen;
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic readReg(logic [4:0] idx, output logic [31:0] v);
    dbgAddr = idx; #1; v = dbgData;
  endtask

  task automatic doOp(string tag, logic [31:0] w, logic [31:0] pc, logic [31:0] exp);
    logic [31:0] v;
    logic [4:0] rd;
    rd = w[11:7];
    exec(w, pc);
    if (rd != 0) mdl[rd] = exp;
    readReg(rd, v);
    check(tag, v, (rd == 0) ? 32'h0 : exp);
  endtask

  task automatic checkAll(string tag);
    logic [31:0] v;
    int bad = 0;
    logic [31:0] fa = 0, fe = 0;
    for (int i = 0; i < 32; i++) begin
      readReg(5'(i), v);
      if (v !== mdl[i] && bad == 0) begin fa = v; fe = mdl[i]; end
      if (v !== mdl[i]) bad++;
    end
    nChecks++;
    if (bad != 0) begin
      nFails++;
      $display("FAIL %s register state actual=%08h expected=%08h", tag, fa, fe);
    end
  endtask

  task automatic testReset();
    check("R11 reset illegal", {31'b0, illegal}, 32'h0);
    checkAll("R11 reset clears all");
  endtask

  task automatic testLogic();
    doOp("R2 addi neg", encI(12'hFFB, 0, 3'b000, 1, OI), 0, 32'hFFFF_FFFB);
    doOp("R7 xori -1", encI(12'hFFF, 1, 3'b100, 2, OI), 0, 32'h0000_0004);
    doOp("R7 ori", encI(12'h0F0, 2, 3'b110, 23, OI), 0, 32'h0000_00F4);
    doOp("R2 andi signext", encI(12'hFF0, 1, 3'b111, 24, OI), 0, 32'hFFFF_FFF0);
    doOp("R7 xor", encR(7'h00, 2, 1, 3'b100, 25, OR_), 0, 32'hFFFF_FFFF);
    doOp("R7 or", encR(7'h00, 23, 2, 3'b110, 26, OR_), 0, 32'h0000_00F4);
    doOp("R7 and", encR(7'h00, 23, 1, 3'b111, 27, OR_), 0, 32'h0000_00F0);
  endtask

  task automatic testArith();
    exec(encU(20'h80000, 3, OU), 0); mdl[3] = 32'h8000_0000;
    doOp("R4 build const", encI(12'hFFF, 3, 3'b000, 3, OI), 0, 32'h7FFF_FFFF);
    doOp("R4 addi overflow", encI(12'h001, 3, 3'b000, 4, OI), 0, 32'h8000_0000);
    doOp("R4 add overflow", encR(7'h00, 3, 3, 3'b000, 5, OR_), 0, 32'hFFFF_FFFE);
    doOp("R4 sub", encR(7'h20, 1, 0, 3'b000, 6, OR_), 0, 32'h0000_0005);
    doOp("R4 sub wrap", encR(7'h20, 4, 0, 3'b000, 28, OR_), 0, 32'h8000_0000);
    doOp("R4 addi -1", encI(12'hFFF, 0, 3'b000, 7, OI), 0, 32'hFFFF_FFFF);
    doOp("R4 wrap to zero", encI(12'h001, 7, 3'b000, 7, OI), 0, 32'h0);
    doOp("R4 addi bit30 set stays add", encI(12'h400, 0, 3'b000, 30, OI), 0, 32'h0000_0400);
  endtask

  task automatic testShift();
    doOp("R5 slli", encI(12'h004, 1, 3'b001, 8, OI), 0, 32'hFFFF_FFB0);
    doOp("R5 srli", encI(12'h01C, 8, 3'b101, 9, OI), 0, 32'h0000_000F);
    doOp("R5 srai", encI(12'h404, 8, 3'b101, 10, OI), 0, 32'hFFFF_FFFB);
    doOp("R5 amount 33", encI(12'h021, 0, 3'b000, 11, OI), 0, 32'h0000_0021);
    doOp("R5 sll low5", encR(7'h00, 11, 3, 3'b001, 12, OR_), 0, 32'hFFFF_FFFE);
    doOp("R5 sra", encR(7'h20, 11, 8, 3'b101, 13, OR_), 0, 32'hFFFF_FFD8);
    doOp("R5 srl", encR(7'h00, 11, 8, 3'b101, 14, OR_), 0, 32'h7FFF_FFD8);
  endtask

  task automatic testCompare();
    doOp("R6 slti", encI(12'hFFC, 1, 3'b010, 15, OI), 0, 32'h1);
    doOp("R6 sltiu signext", encI(12'hFFC, 1, 3'b011, 16, OI), 0, 32'h1);
    doOp("R6 sltiu 1", encI(12'h001, 1, 3'b011, 17, OI), 0, 32'h0);
    doOp("R6 slt", encR(7'h00, 1, 3, 3'b010, 18, OR_), 0, 32'h0);
    doOp("R6 sltu", encR(7'h00, 1, 3, 3'b011, 19, OR_), 0, 32'h1);
  endtask

  task automatic testUpper();
    doOp("R8 lui", encU(20'hABCDE, 20, OU), 0, 32'hABCD_E000);
    doOp("R8 auipc", encU(20'h00001, 21, OP), 32'h0000_0100, 32'h0000_1100);
    doOp("R8 auipc neg", encU(20'hFFFFF, 29, OP), 32'h0000_2000, 32'h0000_1000);
    doOp("R1 fixed slices add", encR(7'h00, 21, 20, 3'b000, 22, OR_), 0, 32'hABCD_F100);
  endtask

  task automatic testZeroReg();
    logic [31:0] v;
    exec(encI(12'h005, 0, 3'b000, 0, OI), 0);
    readReg(0, v); check("R3 x0 addi discarded", v, 32'h0);
    exec(encU(20'h12345, 0, OU), 0);
    checkAll("R3 x0 lui discarded");
    doOp("R3 x0 operand", encR(7'h00, 0, 0, 3'b110, 31, OR_), 0, 32'h0);
  endtask

  task automatic testNop();
    exec(32'h0000_0013, 0);
    check("R9 nop flag", {30'b0, sawNop, sawIll}, 32'h2);
    checkAll("R9 nop no effect");
    exec(encI(12'h001, 0, 3'b000, 0, OI), 0);
    check("R9 non-canonical not nop", {31'b0, sawNop}, 32'h0);
    exec(encI(12'h000, 1, 3'b000, 1, OI), 0);
    check("R9 mv self not nop", {31'b0, sawNop}, 32'h0);
    checkAll("R9 mv self keeps value");
  endtask

  task automatic tryIllegal(string tag, logic [31:0] w);
    exec(w, 0);
    check(tag, {30'b0, sawIll, sawNop}, 32'h2);
    checkAll(tag);
  endtask

  task automatic testIllegal();
    tryIllegal("R10 load opcode", encI(12'h000, 1, 3'b010, 5, 7'b0000011));
    tryIllegal("R10 op alt xor", encR(7'h20, 2, 1, 3'b100, 5, OR_));
    tryIllegal("R10 op funct7 01", encR(7'h01, 2, 1, 3'b000, 5, OR_));
    tryIllegal("R10 slli bit30", encI(12'h401, 1, 3'b001, 5, OI));
    tryIllegal("R10 srli stray bit", encI(12'h021, 1, 3'b101, 5, OI));
    tryIllegal("R10 low bits 01", encI(12'h005, 0, 3'b000, 5, 7'b0010001));
  endtask

  task automatic testIdle();
    @(negedge clk);
    instWord = encI(12'h063, 0, 3'b000, 5, OI); instValid = 1'b0;
    #1; check("R11 idle flags", {30'b0, illegal, nopSeen}, 32'h0);
    @(negedge clk);
    instWord = 32'h0000_0000;
    #1; check("R10 no illegal when idle", {31'b0, illegal}, 32'h0);
    checkAll("R11 idle no write");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testLogic();
    testArith();
    testShift();
    testCompare();
    testUpper();
    testZeroReg();
    testNop();
    testIllegal();
    testIdle();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule